// File: doc/BRIEF.md
# PC-Indexed Two-Bit Counter Table

This block predicts the direction of conditional branches. It is a table of small saturating counters with one counter per entry. A slice of the program counter picks the entry, and no tag is stored. A fetch or decode stage presents a PC on the lookup side and gets back a taken or not-taken guess in the same cycle, with no clock edge in the path. When the branch later resolves, the execute stage sends the same PC and the real outcome on the update side. The addressed counter then moves one step toward that outcome on the next clock edge.

By default each counter has two bits. A two-bit counter only changes its guess after two outcomes in a row go against it, so a loop-closing branch costs one miss per loop instead of two. For comparison, a parameter can shrink every entry to a single bit that simply remembers the last outcome. Branches whose PCs share the index bits share one counter and are not told apart. A synchronous reset loads every entry with a configurable starting state.

Top module: `bht_predictor`

## Requirements
- R1: The entry index is PC bits [IDX_W+1:2], where IDX_W = log2(ENTRIES). PCs that differ only in bits [1:0] or in bits above the index read and update the same entry.
- R2: In two-bit mode the counter codes are 0 = strongly not taken, 1 = weakly not taken, 2 = weakly taken and 3 = strongly taken. The prediction is taken exactly for codes 2 and 3.
- R3: In two-bit mode a taken update adds one to the code and a not-taken update subtracts one. The code saturates at 3 and at 0.
- R4: A two-bit entry in a strong state keeps its prediction after one contrary outcome. It flips only after a second contrary outcome in a row.
- R5: With CTR_BITS = 1 an entry holds only the last outcome and predicts that outcome. A loop branch taken three times and then not taken misses twice in every repeat of the loop. In two-bit mode, after the first pass, the same loop misses once per repeat.
- R6: While rst is high at a clock edge, every entry is loaded with RESET_STATE. In one-bit mode the entry takes RESET_STATE bit 1. From the next cycle every PC predicts RESET_STATE bit 1, which is not taken for the default code 1.
- R7: lk_taken follows lk_pc combinationally. An entry changes only at a clock edge where up_valid is high. With up_valid low, up_pc and up_taken have no effect.
- R8: When the lookup and the update address the same entry in one cycle, lk_taken shows the state from before the update. The new state appears after the clock edge.
- R9: An update changes only the entry it addresses. All other entries keep their state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| lk_pc | input | PC_W | PC to predict |
| lk_taken | output | 1 | Prediction for lk_pc, 1 = taken |
| up_valid | input | 1 | Apply an update at this clock edge |
| up_pc | input | PC_W | PC of the resolved branch |
| up_taken | input | 1 | Resolved outcome, 1 = taken |

## Verification
The bench checks the counter walk with short directed runs on one entry:
- one contrary outcome from a strong state, which shows hysteresis;
- two contrary outcomes, which show the flip;
- a run of repeated not-taken outcomes followed by a single taken one, which exposes any wrap past zero.

A taken-taken-taken-not-taken loop is fed to a one-bit and a two-bit instance side by side, and the miss counts per loop repeat (2 against 1) separate the two modes. Further directed cases cover:
- PCs that differ only in ignored bits (aliasing);
- an idle update port carrying a live PC;
- a lookup and an update to the same entry in one cycle.

Seeded random traffic, confined to a few indices with random high and low PC bits, is compared every cycle against a model of the table kept in the bench. This catches writes that land on the wrong entry or that bleed into neighbouring entries.

// File: rtl/bht_pkg.sv
package bht_pkg;

  typedef enum logic [1:0] {
    CTR_SNT = 2'd0,
    CTR_WNT = 2'd1,
    CTR_WT  = 2'd2,
    CTR_ST  = 2'd3
  } ctr2_e;

  // saturating step of a two-bit counter toward the resolved outcome
  function automatic logic [1:0] ctr2_next(input logic [1:0] cur, input logic taken);
    logic [1:0] res;
    if (taken) res = (cur == CTR_ST)  ? cur : cur + 2'd1;
    else       res = (cur == CTR_SNT) ? cur : cur - 2'd1;
    return res;
  endfunction

  // taken when the upper half of the range is reached
  function automatic logic ctr2_pred(input logic [1:0] cur);
    return cur[1];
  endfunction

endpackage

// File: rtl/bht_index.sv
module bht_index #(
  parameter int PC_W  = 32,
  parameter int IDX_W = 10
) (
  input  logic [PC_W-1:0]  pc,
  output logic [IDX_W-1:0] idx
);
  // byte-offset bits and bits above the index are not part of the lookup
  logic unused_pc_bits;
  assign unused_pc_bits = ^{pc[1:0], pc[PC_W-1:IDX_W+2]};
  assign idx = pc[IDX_W+1:2];
endmodule

// File: rtl/bht_ctr_step.sv
module bht_ctr_step #(
  parameter int CTR_W = 2
) (
  input  logic [CTR_W-1:0] cur,
  input  logic             taken,
  output logic [CTR_W-1:0] nxt
);
  import bht_pkg::*;
  generate
    if (CTR_W == 2) begin : g_two_bit
      assign nxt = ctr2_next(cur, taken);
    end else begin : g_one_bit
      logic unused_cur;
      assign unused_cur = ^cur;
      assign nxt = taken;
    end
  endgenerate
endmodule

// File: rtl/bht_table.sv
module bht_table #(
  parameter int ENTRIES = 1024,
  parameter int CTR_W   = 2,
  parameter logic [CTR_W-1:0] RST_VAL = '0,
  localparam int IDX_W = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [CTR_W-1:0] rd_val,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [CTR_W-1:0] wr_val,
  output logic [CTR_W-1:0] wr_old
);
  logic [CTR_W-1:0] mem [ENTRIES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ENTRIES; i++) mem[i] <= RST_VAL;
    end else if (wr_en) begin
      mem[wr_idx] <= wr_val;
    end
  end

  assign rd_val = mem[rd_idx];
  assign wr_old = mem[wr_idx];
endmodule

// File: rtl/bht_predictor.sv
module bht_predictor #(
  parameter int PC_W        = 32,
  parameter int ENTRIES     = 1024,
  parameter int CTR_BITS    = 2,
  parameter logic [1:0] RESET_STATE = 2'b01
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PC_W-1:0] lk_pc,
  output logic            lk_taken,
  input  logic            up_valid,
  input  logic [PC_W-1:0] up_pc,
  input  logic            up_taken
);
  localparam int IDX_W = $clog2(ENTRIES);
  localparam logic [CTR_BITS-1:0] RST_ENTRY = RESET_STATE[1 -: CTR_BITS];

  logic [IDX_W-1:0]    lk_idx, up_idx;
  logic [CTR_BITS-1:0] lk_ctr, wr_old, wr_new;

  bht_index #(.PC_W(PC_W), .IDX_W(IDX_W)) i_lk_index (.pc(lk_pc), .idx(lk_idx));
  bht_index #(.PC_W(PC_W), .IDX_W(IDX_W)) i_up_index (.pc(up_pc), .idx(up_idx));

  bht_ctr_step #(.CTR_W(CTR_BITS)) i_step (.cur(wr_old), .taken(up_taken), .nxt(wr_new));

  bht_table #(.ENTRIES(ENTRIES), .CTR_W(CTR_BITS), .RST_VAL(RST_ENTRY)) i_table (
    .clk(clk), .rst(rst),
    .rd_idx(lk_idx), .rd_val(lk_ctr),
    .wr_en(up_valid), .wr_idx(up_idx), .wr_val(wr_new), .wr_old(wr_old)
  );

  assign lk_taken = lk_ctr[CTR_BITS-1];

  // ---------------- assertions ----------------
  logic past_ok = 1'b0;
  always_ff @(posedge clk) past_ok <= 1'b1;

  assert_reset_value_R6: assert property (@(posedge clk)
    past_ok && $past(rst) |-> lk_taken == RESET_STATE[1]);

  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (rst)
    past_ok && !$past(rst) && !$past(up_valid) && $stable(lk_pc) |-> $stable(lk_taken));

  generate
    if (CTR_BITS == 2) begin : g_chk_two
      assert_sat_top_R3: assert property (@(posedge clk) disable iff (rst)
        up_valid && up_taken && wr_old == 2'd3 |-> wr_new == 2'd3);
      assert_sat_bottom_R3: assert property (@(posedge clk) disable iff (rst)
        up_valid && !up_taken && wr_old == 2'd0 |-> wr_new == 2'd0);
      assert_strong_keeps_R4: assert property (@(posedge clk) disable iff (rst)
        up_valid && (wr_old == 2'd3 || wr_old == 2'd0) |-> wr_new[1] == wr_old[1]);
    end else begin : g_chk_one
      assert_last_outcome_R5: assert property (@(posedge clk) disable iff (rst)
        past_ok && !$past(rst) && $past(up_valid) && $past(up_idx) == lk_idx
        |-> lk_taken == $past(up_taken));
    end
  endgenerate
endmodule

// File: tb/test_bht_predictor.sv
module test_bht_predictor;
  localparam int CLK_PERIOD = 10;
  localparam int PC_W = 32;
  localparam int ENTRIES = 1024;
  localparam int IDXW = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [PC_W-1:0] lk_pc = '0, up_pc = '0;
  logic up_valid = 1'b0, up_taken = 1'b0;
  logic pred2, pred1;

  int n_checks = 0, n_fail = 0;
  int m2 [ENTRIES];
  bit m1 [ENTRIES];

  always #(CLK_PERIOD/2) clk = ~clk;

  bht_predictor #(.PC_W(PC_W), .ENTRIES(ENTRIES), .CTR_BITS(2), .RESET_STATE(2'b01)) i_bht_predictor (
    .clk(clk), .rst(rst), .lk_pc(lk_pc), .lk_taken(pred2),
    .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken));

  bht_predictor #(.PC_W(PC_W), .ENTRIES(ENTRIES), .CTR_BITS(1), .RESET_STATE(2'b01)) i_bht_predictor_1b (
    .clk(clk), .rst(rst), .lk_pc(lk_pc), .lk_taken(pred1),
    .up_valid(up_valid), .up_pc(up_pc), .up_taken(up_taken));

  function automatic int ref_idx(input logic [PC_W-1:0] pc);
    return int'((pc / 4) % ENTRIES);
  endfunction

  function automatic int ref_sat(input int s, input bit t);
    int r;
    r = t ? s + 1 : s - 1;
    if (r > 3) r = 3;
    if (r < 0) r = 0;
    return r;
  endfunction

  function automatic logic [PC_W-1:0] mkpc(input int idx, input int hi, input int lo);
    return (PC_W'(hi) << (IDXW + 2)) | (PC_W'(idx) << 2) | PC_W'(lo & 3);
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < ENTRIES; i++) begin m2[i] = 1; m1[i] = 1'b0; end
  endtask

  // drive one cycle, compare pre-edge predictions to the model, apply the edge
  task automatic step(input string tag, input logic [PC_W-1:0] lpc, input logic v,
                      input logic [PC_W-1:0] upc, input logic t);
    lk_pc = lpc; up_valid = v; up_pc = upc; up_taken = t;
    #1;
    check({tag, " two-bit"}, int'(pred2), int'(m2[ref_idx(lpc)] >= 2));
    check({tag, " one-bit"}, int'(pred1), int'(m1[ref_idx(lpc)]));
    @(posedge clk);
    if (v) begin
      m2[ref_idx(upc)] = ref_sat(m2[ref_idx(upc)], t);
      m1[ref_idx(upc)] = t;
    end
    @(negedge clk);
    up_valid = 1'b0;
  endtask

  task automatic upd(input logic [PC_W-1:0] pc, input logic t);
    step("R7 update", pc, 1'b1, pc, t);
  endtask

  // literal expectations from the requirements
  task automatic peek(input string tag, input logic [PC_W-1:0] pc, input int e2, input int e1);
    lk_pc = pc; up_valid = 1'b0;
    #1;
    check({tag, " two-bit"}, int'(pred2), e2);
    check({tag, " one-bit"}, int'(pred1), e1);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_checks++; n_fail++;
    $display("FAIL watchdog: got %0d expected %0d", 0, 1);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    logic [PC_W-1:0] pa, pb, pl;
    int miss1, miss2;
    void'($urandom(32'd4321));
    model_reset();
    @(negedge clk); @(negedge clk);
    rst = 1'b0;

    // R6 reset state: weakly not taken / 0
    peek("R6 reset", mkpc(0, 0, 0), 0, 0);
    peek("R6 reset", mkpc(ENTRIES-1, 7, 3), 0, 0);
    peek("R6 reset", mkpc(513, 2, 1), 0, 0);

    // R2/R3/R4 counter walk on one entry, starting at code 1
    pa = mkpc(20, 0, 0);
    upd(pa, 1); peek("R2 weak taken", pa, 1, 1);          // 2
    upd(pa, 1); upd(pa, 0); peek("R4 one contrary", pa, 1, 0); // 3 -> 2
    upd(pa, 1); upd(pa, 0); upd(pa, 0); peek("R4 two contrary", pa, 0, 0); // 3,2,1
    upd(pa, 0); upd(pa, 0); upd(pa, 0); upd(pa, 1);
    peek("R3 saturate low", pa, 0, 1);                     // 0,0,0 -> 1
    upd(pa, 1); peek("R3 count up", pa, 1, 1);             // 2

    // R7 idle update port with live PC and outcome
    step("R7 idle", pa, 1'b0, pa, 1'b0);
    step("R7 idle", pa, 1'b0, pa, 1'b0);
    step("R7 idle", pa, 1'b0, pa, 1'b0);
    peek("R7 idle hold", pa, 1, 1);

    // R8 same-entry lookup and update in one cycle
    lk_pc = pa; up_valid = 1'b1; up_pc = pa; up_taken = 1'b0;
    #1;
    check("R8 pre-update two-bit", int'(pred2), 1);
    check("R8 pre-update one-bit", int'(pred1), 1);
    @(posedge clk);
    m2[ref_idx(pa)] = ref_sat(m2[ref_idx(pa)], 1'b0); m1[ref_idx(pa)] = 1'b0;
    @(negedge clk); up_valid = 1'b0;
    peek("R8 post-update", pa, 0, 0);

    // R1 aliasing through ignored bits, R9 neighbour untouched
    pb = mkpc(21, 0, 0);
    upd(mkpc(21, 5, 3), 1); upd(mkpc(21, 9, 2), 1);
    peek("R1 alias", pb, 1, 1);
    peek("R9 neighbour", mkpc(22, 0, 0), 0, 0);

    // R5 loop branch: T,T,T,N repeated three times
    pl = mkpc(40, 1, 0);
    for (int rep = 0; rep < 3; rep++) begin
      miss1 = 0; miss2 = 0;
      for (int it = 0; it < 4; it++) begin
        logic t;
        t = (it < 3);
        lk_pc = pl; #1;
        if (pred1 != t) miss1++;
        if (pred2 != t) miss2++;
        step("R5 loop", pl, 1'b1, pl, t);
      end
      if (rep > 0) begin
        check("R5 one-bit misses per loop", miss1, 2);
        check("R5 two-bit misses per loop", miss2, 1);
      end
    end

    // R9/R1 random traffic on a few indices with random ignored bits
    for (int n = 0; n < 3000; n++) begin
      logic [PC_W-1:0] l, u;
      l = mkpc(int'($urandom % 16), int'($urandom % 64), int'($urandom % 4));
      u = mkpc(int'($urandom % 16), int'($urandom % 64), int'($urandom % 4));
      step("R9 random", l, 1'($urandom % 10 < 7), u, 1'($urandom % 2));
    end

    // R6 reset after traffic
    rst = 1'b1;
    @(posedge clk); model_reset();
    @(negedge clk); rst = 1'b0;
    peek("R6 re-reset", pb, 0, 0);
    peek("R6 re-reset", mkpc(3, 11, 2), 0, 0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule